// File: doc/BRIEF.md
# Hierarchical Hit Address Encoder Tree

This block performs zero-suppressed readout of the pixel state bits in one double column, 1024 bits at the default depth. A combinational tree of identical four-input arbiter units sits over the state bits. Each unit reports whether any of its inputs is set, plus the 2-bit index of the lowest set input. Each unit also passes a clear pulse from its parent down to that winning input only. The root therefore presents a single valid flag and the full address of the lowest-index active pixel. A clear pulse driven into the root arrives at exactly that pixel.

A small clocked controller drains the tree after a start pulse. On a sample cycle it captures the root address, emits it with a one-cycle strobe and raises the clear pulse. The pixel drops its hit on the falling edge of that pulse, one cycle later, so the address is stable while it is captured. The next hit is sampled on the following cycle. A readout of n hits therefore takes 2n+1 cycles and ends with a sticky done flag.

Top module: `hit_tree_readout`

## Requirements
- R1: After reset, addr_valid_o and done_o are 0, addr_o is 0 and every pix_rst_o bit is 0.
- R2: A start_i sampled high by a rising edge while the controller is idle begins a readout. If any state bit is set, the first address appears with addr_valid_o high in the cycle after the next rising edge.
- R3: Addresses are emitted in strictly ascending pixel index order. The lowest index wins in every unit. addr_o equals the pixel index, with the top tree level supplying bits [9:8] and the leaf level bits [1:0].
- R4: addr_valid_o is high for exactly one cycle per hit, and successive strobes are two cycles apart.
- R5: During a strobe cycle pix_rst_o has exactly the bit at index addr_o set. In every other cycle all pix_rst_o bits are 0.
- R6: A readout of n set bits yields exactly n strobes, and every state bit is clear when it ends, given pixels that clear on the falling edge of their pix_rst_o bit.
- R7: done_o rises 2n+1 rising edges after the start edge, is never high with addr_valid_o, and stays high until the next accepted start_i, which clears it. With no hits it rises one edge after the start edge.
- R8: start_i has no effect while a readout is in progress.
- R9: addr_o holds the last emitted address between strobes.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Readout start pulse |
| state_i | input | 1024 | Pixel state bits, index = pixel address |
| addr_o | output | 10 | Emitted hit address |
| addr_valid_o | output | 1 | One-cycle strobe qualifying addr_o |
| done_o | output | 1 | Readout finished, sticky until next start |
| pix_rst_o | output | 1024 | Per-pixel clear lines routed by the tree |

## Verification
Counting from the rising edge that accepts start_i, hit j is due one cycle after edge 2j+1 and done one cycle after edge 2n+1. The pixel clear line and the strobe share that cycle, because the clear is a registered controller output routed through combinational logic. The bench model counts edges from the start edge with an integer and derives the expected strobe, address, clear lines and done flag from an ascending list of the set bits. It compares all four half a period after every rising edge, so each result is read in the cycle it becomes due and never across an edge.

// File: rtl/hit_tree_pkg.sv
package hit_tree_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SAMPLE, ST_CLEAR} rd_state_e;

  // first flat node index of tree level l (level 0 = pixels)
  function automatic int lvl_off(int n, int l);
    int s = 0;
    for (int k = 0; k < l; k++) s += n >> (2 * k);
    return s;
  endfunction
endpackage

// File: rtl/arb4_unit.sv
module arb4_unit (
  input  logic [3:0] state_i,
  input  logic       sync_i,
  output logic       valid_o,
  output logic [1:0] addr_o,
  output logic [3:0] sync_o
);
  logic [3:0] gnt;

  always_comb begin
    gnt[0] = state_i[0];
    gnt[1] = state_i[1] & ~state_i[0];
    gnt[2] = state_i[2] & ~|state_i[1:0];
    gnt[3] = state_i[3] & ~|state_i[2:0];
  end

  assign valid_o = |state_i;
  assign addr_o  = {gnt[3] | gnt[2], gnt[3] | gnt[1]};
  assign sync_o  = gnt & {4{sync_i}};
endmodule

// File: rtl/hit_tree.sv
module hit_tree
  import hit_tree_pkg::*;
#(
  parameter  int LEVELS = 5,
  localparam int N      = 1 << (2 * LEVELS),
  localparam int AW     = 2 * LEVELS
) (
  input  logic [N-1:0]  state_i,
  input  logic          sync_i,
  output logic          valid_o,
  output logic [AW-1:0] addr_o,
  output logic [N-1:0]  pix_rst_o
);
  localparam int INT = (N - 1) / 3;
  localparam int TOT = N + INT;

  logic [TOT-1:0]   v_all;
  logic [TOT-1:0]   s_all;
  logic [2*INT-1:0] a_all;

  assign v_all[N-1:0] = state_i;
  assign s_all[TOT-1] = sync_i;

  for (genvar l = 1; l <= LEVELS; l++) begin : g_lvl
    for (genvar j = 0; j < (N >> (2 * l)); j++) begin : g_node
      localparam int SELF = lvl_off(N, l) + j;
      localparam int CH   = lvl_off(N, l - 1) + 4 * j;
      arb4_unit u_unit (
        .state_i(v_all[CH +: 4]),
        .sync_i (s_all[SELF]),
        .valid_o(v_all[SELF]),
        .addr_o (a_all[2*(SELF-N) +: 2]),
        .sync_o (s_all[CH +: 4])
      );
    end
  end

  // follow winners from root to leaf; top level lands in the MSBs
  always_comb begin
    int idx;
    idx = 0;
    for (int l = LEVELS; l >= 1; l--)
      idx = idx * 4 + int'(a_all[2*(lvl_off(N, l) + idx - N) +: 2]);
    addr_o = AW'(idx);
  end

  assign valid_o   = v_all[TOT-1];
  assign pix_rst_o = s_all[N-1:0];
endmodule

// File: rtl/rd_ctrl.sv
module rd_ctrl
  import hit_tree_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          tree_valid_i,
  input  logic [AW-1:0] tree_addr_i,
  output logic          sync_o,
  output logic [AW-1:0] addr_o,
  output logic          addr_valid_o,
  output logic          done_o
);
  rd_state_e st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_IDLE;
      sync_o       <= 1'b0;
      addr_o       <= '0;
      addr_valid_o <= 1'b0;
      done_o       <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q   <= ST_SAMPLE;
          done_o <= 1'b0;
        end
        ST_SAMPLE: if (tree_valid_i) begin
          addr_o       <= tree_addr_i;
          addr_valid_o <= 1'b1;
          sync_o       <= 1'b1;
          st_q         <= ST_CLEAR;
        end else begin
          done_o <= 1'b1;
          st_q   <= ST_IDLE;
        end
        // sync falls here: the pixel drops its hit before the next sample
        ST_CLEAR: begin
          addr_valid_o <= 1'b0;
          sync_o       <= 1'b0;
          st_q         <= ST_SAMPLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hit_tree_readout.sv
module hit_tree_readout #(
  parameter  int LEVELS = 5,
  localparam int N      = 1 << (2 * LEVELS),
  localparam int AW     = 2 * LEVELS
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [N-1:0]  state_i,
  output logic [AW-1:0] addr_o,
  output logic          addr_valid_o,
  output logic          done_o,
  output logic [N-1:0]  pix_rst_o
);
  logic          tree_valid;
  logic [AW-1:0] tree_addr;
  logic          sync;

  hit_tree #(.LEVELS(LEVELS)) u_tree (
    .state_i  (state_i),
    .sync_i   (sync),
    .valid_o  (tree_valid),
    .addr_o   (tree_addr),
    .pix_rst_o(pix_rst_o)
  );

  rd_ctrl #(.AW(AW)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .tree_valid_i(tree_valid),
    .tree_addr_i (tree_addr),
    .sync_o      (sync),
    .addr_o      (addr_o),
    .addr_valid_o(addr_valid_o),
    .done_o      (done_o)
  );
endmodule

// File: rtl/hit_tree_readout_chk.sv
module hit_tree_readout_chk #(
  parameter  int LEVELS = 5,
  localparam int N      = 1 << (2 * LEVELS),
  localparam int AW     = 2 * LEVELS
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] addr_o,
  input logic          addr_valid_o,
  input logic          done_o,
  input logic [N-1:0]  pix_rst_o
);
  logic [AW-1:0] last_q;
  logic          seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q <= '0;
      seen_q <= 1'b0;
    end else if (done_o) begin
      seen_q <= 1'b0;
    end else if (addr_valid_o) begin
      seen_q <= 1'b1;
      last_q <= addr_o;
    end
  end

  AST_RST_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pix_rst_o)); // R5
  AST_RST_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_valid_o |-> pix_rst_o[addr_o]); // R5
  AST_RST_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addr_valid_o |-> (pix_rst_o == '0)); // R5
  AST_STROBE_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_valid_o |=> !addr_valid_o); // R4
  AST_DONE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !addr_valid_o); // R7
  AST_ASCENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_valid_o && seen_q) |-> (addr_o > last_q)); // R3
endmodule

bind hit_tree_readout hit_tree_readout_chk #(.LEVELS(LEVELS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .addr_o      (addr_o),
  .addr_valid_o(addr_valid_o),
  .done_o      (done_o),
  .pix_rst_o   (pix_rst_o)
);

// File: tb/hit_tree_readout_test.sv
module hit_tree_readout_test;
  localparam int N  = 1024;
  localparam int AW = 10;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b1;
  logic          start_i = 1'b0;
  logic [N-1:0]  state_i;
  logic [AW-1:0] addr_o;
  logic          addr_valid_o;
  logic          done_o;
  logic [N-1:0]  pix_rst_o;

  logic [N-1:0] hits_cur = '0;
  logic [N-1:0] rst_prev = '0;
  int n_cmp = 0, n_bad = 0, strobe_cnt = 0;
  bit finished = 0;

  // reference model state
  int          exp_list[$];
  bit          run = 0, exp_done = 0;
  int          t = 0;
  logic [AW-1:0] exp_addr = '0;

  assign state_i = hits_cur;

  hit_tree_readout uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .state_i(state_i),
    .addr_o(addr_o), .addr_valid_o(addr_valid_o), .done_o(done_o),
    .pix_rst_o(pix_rst_o)
  );

  always #2 clk_i = ~clk_i;

  // pixel model: hit drops on the falling edge of its clear line
  always @(pix_rst_o) begin
    hits_cur = hits_cur & ~(rst_prev & ~pix_rst_o);
    rst_prev = pix_rst_o;
  end

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run = 0; exp_done = 0; t = 0; exp_addr = '0;
    end else if (!run && start_i) begin
      exp_list.delete();
      for (int i = 0; i < N; i++) if (hits_cur[i]) exp_list.push_back(i);
      run = 1; exp_done = 0; t = 0;
    end else if (run) begin
      t++;
      if (t % 2 == 1) begin
        if ((t - 1) / 2 < exp_list.size()) exp_addr = AW'(exp_list[(t-1)/2]);
        else begin exp_done = 1; run = 0; end
      end
    end
  end

  function automatic int rst_code(logic [N-1:0] v);
    if (v == '0) return -1;
    if ($countones(v) != 1) return -2;
    for (int i = 0; i < N; i++) if (v[i]) return i;
    return -3;
  endfunction

  task automatic check(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) if (!finished) begin
    bit exp_strobe;
    logic [N-1:0] exp_rst;
    exp_strobe = run && (t % 2 == 1) && ((t - 1) / 2 < exp_list.size());
    exp_rst = '0;
    if (exp_strobe) exp_rst[exp_addr] = 1'b1;
    if (addr_valid_o) strobe_cnt++;
    check("R2/R4 strobe", int'(addr_valid_o), int'(exp_strobe));
    check("R3/R9 addr", int'(addr_o), int'(exp_addr));
    check("R7 done", int'(done_o), int'(exp_done));
    check("R5 pix_rst", rst_code(pix_rst_o), rst_code(exp_rst));
  end

  task automatic readout(logic [N-1:0] pat, bit mid_start, string req);
    int n, guard;
    n = $countones(pat);
    @(negedge clk_i);
    hits_cur = pat;
    strobe_cnt = 0;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    if (mid_start) begin
      repeat (3) @(negedge clk_i);
      start_i = 1'b1;          // R8: must be ignored
      @(negedge clk_i);
      start_i = 1'b0;
    end
    guard = 0;
    while (!done_o && guard < 5000) begin @(negedge clk_i); guard++; end
    check({req, " strobes"}, strobe_cnt, n);
    check("R6 all cleared", $countones(hits_cur), 0);
    repeat (2) @(negedge clk_i);
    check("R7 done sticky", int'(done_o), 1);
  endtask

  initial begin
    logic [N-1:0] p;
    logic [15:0] lfsr;
    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    check("R1 valid", int'(addr_valid_o), 0);
    check("R1 done", int'(done_o), 0);
    check("R1 addr", int'(addr_o), 0);
    check("R1 pix_rst", rst_code(pix_rst_o), -1);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    readout('0, 0, "R7 empty");
    p = '0; p[0] = 1'b1;      readout(p, 0, "R2 bit0");
    p = '0; p[N-1] = 1'b1;    readout(p, 0, "R3 top bit");
    p = '0; p[3:0] = 4'hF;    readout(p, 0, "R3 one leaf");
    p = '0; p[3] = 1; p[4] = 1; p[15] = 1; p[16] = 1; p[63] = 1; p[64] = 1;
    p[255] = 1; p[256] = 1; p[767] = 1; p[1022] = 1;
    readout(p, 0, "R3 branch edges");
    p = '0; lfsr = 16'hACE1;
    for (int i = 0; i < N; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[2:0] == 3'd0) p[i] = 1'b1;
    end
    readout(p, 0, "R6 sparse");
    readout({N{1'b1}}, 1, "R8 full with mid start");
    p = '0; p[512] = 1'b1;    readout(p, 0, "R7 restart");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL R7 watchdog act=running exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule